// File: doc/BRIEF.md
# Floating-Point Error Gate

This block sits at the issue point of a floating-point pipeline and decides, for each instruction handed to it by the decoder, whether the instruction may proceed while a numeric exception is outstanding. It looks at the error-reporting mode bit, an active-low pin that asks the core to disregard pending errors, the pending-unmasked-exception flag, a strap that selects dual-processor operation and a 4-bit instruction class that arrives with a valid strobe. From these it produces exactly one of three one-cycle strobes: run the instruction, report an internal exception, or freeze.

A small set of control-type instructions (those that initialise, clear, save or inspect the floating-point state) are allowed through a pending error so that software can recover. Any other floating-point instruction stops the pipeline, and the block then holds a frozen flag until an external interrupt request is seen. Release is marked by a one-cycle resume strobe. Instructions that are not floating-point pass through untouched.

Top module: `fpgate_ctrl`

## Requirements
- R1: While `rst` is high at a rising clock edge, all strobes and `frozen_o` are low at the following cycle, and a frozen state is cleared.
- R2: An accepted instruction with `err_pending_i` low gives `exec_o` high for exactly the one cycle after the edge that sampled `ins_valid_i`.
- R3: With `native_err_i` high and an error pending, classes 0..8 give `exec_o`, classes 9..14 give a one-cycle `report_o` and no freeze, whatever `ignore_err_n_i` is.
- R4: With `native_err_i` low, `dual_cfg_i` low, `ignore_err_n_i` low and an error pending, every class gives `exec_o`.
- R5: With `native_err_i` low, the ignore request inactive and an error pending, classes 0..8 (the nine exempt control instructions) give `exec_o`.
- R6: Under the conditions of R5, classes 9..14 give a one-cycle `freeze_o` and set `frozen_o` in the same cycle.
- R7: When `dual_cfg_i` is high, `ignore_err_n_i` low behaves exactly as if it were high.
- R8: Class 15 (not a floating-point instruction) always gives `exec_o` when accepted.
- R9: While `frozen_o` is high, `ins_valid_i` is ignored: no strobe of any kind results.
- R10: At the first rising edge where `frozen_o` is high and `ext_irq_i` is high, `frozen_o` goes low and `resume_o` is high for one cycle; without `ext_irq_i` the frozen state holds.
- R11: With `ins_valid_i` low and not frozen, no strobe is raised; at most one of `exec_o`, `freeze_o`, `report_o`, `resume_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| native_err_i | input | 1 | Native error-reporting mode bit |
| ignore_err_n_i | input | 1 | Active-low request to disregard pending errors |
| err_pending_i | input | 1 | Pending unmasked numeric exception summary flag |
| dual_cfg_i | input | 1 | Dual-processor configuration strap |
| ins_valid_i | input | 1 | Instruction class valid strobe |
| ins_class_i | input | 4 | Decoded instruction class |
| ext_irq_i | input | 1 | External interrupt request |
| exec_o | output | 1 | One-cycle run strobe |
| freeze_o | output | 1 | One-cycle strobe on entering the frozen state |
| report_o | output | 1 | One-cycle internal-exception report strobe |
| resume_o | output | 1 | One-cycle strobe on leaving the frozen state |
| frozen_o | output | 1 | Frozen status flag |

## Verification
The bench sweeps every combination of mode bit, ignore pin, pending flag, strap and all sixteen class codes, so a design that mixed up the boundary between class 8 and class 9, or that honoured the ignore pin in native mode or in dual configuration, would show a wrong strobe in a specific cell of the sweep. Each freeze is followed by a valid class-15 instruction and a wait without interrupt, which catches a design that lets instructions leak through or leaves the frozen state on its own. Release is checked on the exact cycle after the interrupt edge, and a reset during a frozen state confirms that reset, not only an interrupt, clears it.

// File: rtl/fpgate_pkg.sv
package fpgate_pkg;

    // Action chosen for one accepted instruction
    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_RUN    = 2'd1,
        ACT_REPORT = 2'd2,
        ACT_FREEZE = 2'd3
    } act_e;

    // Hold state of the gate
    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HELD = 1'b1
    } hold_e;

    // Conditions derived from the inputs for the instruction under test
    typedef struct packed {
        logic exempt;      // control instruction allowed past an error
        logic non_fp;      // not a floating-point instruction
        logic ignore_eff;  // ignore request after masking
        logic pending;     // unmasked error outstanding
        logic native;      // native error-reporting mode
    } cond_t;

    // Registered output strobes
    typedef struct packed {
        logic exec;
        logic freeze;
        logic report;
        logic resume;
    } strobe_t;

    function automatic act_e resolve_action(input cond_t c);
        act_e a;
        if (c.non_fp || !c.pending) begin
            a = ACT_RUN;
        end else if (c.native) begin
            a = c.exempt ? ACT_RUN : ACT_REPORT;
        end else if (c.ignore_eff || c.exempt) begin
            a = ACT_RUN;
        end else begin
            a = ACT_FREEZE;
        end
        return a;
    endfunction

endpackage

// File: rtl/fpgate_classify.sv
module fpgate_classify
    import fpgate_pkg::*;
#(
    parameter int CLS_W        = 4,
    parameter int EXEMPT_COUNT = 9,
    parameter int NON_FP_CODE  = 15
) (
    input  logic [CLS_W-1:0] cls_i,
    input  logic             native_i,
    input  logic             ignore_n_i,
    input  logic             pending_i,
    input  logic             dual_i,
    output cond_t            cond_o
);
    localparam logic [CLS_W-1:0] EXEMPT_LIMIT = CLS_W'(EXEMPT_COUNT);
    localparam logic [CLS_W-1:0] NON_FP       = CLS_W'(NON_FP_CODE);

    logic pin_masked;

    // The ignore request counts only when active, not strapped off,
    // and the core is not in native mode.
    assign pin_masked = dual_i | native_i;

    always_comb begin
        cond_o            = '0;
        cond_o.exempt     = (cls_i < EXEMPT_LIMIT);
        cond_o.non_fp     = (cls_i == NON_FP);
        cond_o.ignore_eff = ~ignore_n_i & ~pin_masked;
        cond_o.pending    = pending_i;
        cond_o.native     = native_i;
    end

endmodule

// File: rtl/fpgate_resolve.sv
module fpgate_resolve
    import fpgate_pkg::*;
(
    input  logic  valid_i,
    input  logic  held_i,
    input  cond_t cond_i,
    output act_e  act_o
);
    always_comb begin
        if (!valid_i || held_i) begin
            act_o = ACT_NONE;
        end else begin
            act_o = resolve_action(cond_i);
        end
    end

endmodule

// File: rtl/fpgate_hold.sv
module fpgate_hold
    import fpgate_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  act_e    act_i,
    input  logic    irq_i,
    output logic    held_o,
    output strobe_t strb_o
);
    hold_e   state_q;
    strobe_t strb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
            strb_q  <= '0;
        end else begin
            strb_q <= '0;
            case (state_q)
                ST_RUN: begin
                    case (act_i)
                        ACT_RUN:    strb_q.exec   <= 1'b1;
                        ACT_REPORT: strb_q.report <= 1'b1;
                        ACT_FREEZE: begin
                            strb_q.freeze <= 1'b1;
                            state_q       <= ST_HELD;
                        end
                        default: ;
                    endcase
                end
                ST_HELD: begin
                    if (irq_i) begin
                        strb_q.resume <= 1'b1;
                        state_q       <= ST_RUN;
                    end
                end
                default: state_q <= ST_RUN;
            endcase
        end
    end

    assign held_o = (state_q == ST_HELD);
    assign strb_o = strb_q;

endmodule

// File: rtl/fpgate_ctrl.sv
module fpgate_ctrl
    import fpgate_pkg::*;
#(
    parameter int CLS_W        = 4,
    parameter int EXEMPT_COUNT = 9,
    parameter int NON_FP_CODE  = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             native_err_i,
    input  logic             ignore_err_n_i,
    input  logic             err_pending_i,
    input  logic             dual_cfg_i,
    input  logic             ins_valid_i,
    input  logic [CLS_W-1:0] ins_class_i,
    input  logic             ext_irq_i,
    output logic             exec_o,
    output logic             freeze_o,
    output logic             report_o,
    output logic             resume_o,
    output logic             frozen_o
);
    cond_t   cond;
    act_e    act;
    logic    held;
    strobe_t strb;

    fpgate_classify #(
        .CLS_W        (CLS_W),
        .EXEMPT_COUNT (EXEMPT_COUNT),
        .NON_FP_CODE  (NON_FP_CODE)
    ) u_classify (
        .cls_i      (ins_class_i),
        .native_i   (native_err_i),
        .ignore_n_i (ignore_err_n_i),
        .pending_i  (err_pending_i),
        .dual_i     (dual_cfg_i),
        .cond_o     (cond)
    );

    fpgate_resolve u_resolve (
        .valid_i (ins_valid_i),
        .held_i  (held),
        .cond_i  (cond),
        .act_o   (act)
    );

    fpgate_hold u_hold (
        .clk    (clk),
        .rst    (rst),
        .act_i  (act),
        .irq_i  (ext_irq_i),
        .held_o (held),
        .strb_o (strb)
    );

    assign exec_o   = strb.exec;
    assign freeze_o = strb.freeze;
    assign report_o = strb.report;
    assign resume_o = strb.resume;
    assign frozen_o = held;

endmodule

// File: rtl/fpgate_ctrl_chk.sv
module fpgate_ctrl_chk #(
    parameter int CLS_W       = 4,
    parameter int NON_FP_CODE = 15
) (
    input logic             clk,
    input logic             rst,
    input logic             ins_valid_i,
    input logic [CLS_W-1:0] ins_class_i,
    input logic             err_pending_i,
    input logic             ext_irq_i,
    input logic             exec_o,
    input logic             freeze_o,
    input logic             report_o,
    input logic             resume_o,
    input logic             frozen_o
);
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({exec_o, freeze_o, report_o, resume_o})); // R11

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!frozen_o && !ins_valid_i) |=> !(exec_o || freeze_o || report_o)); // R11

    AST_FREEZE_FLAG: assert property (@(posedge clk) disable iff (rst)
        freeze_o |-> frozen_o); // R6

    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (frozen_o && !ext_irq_i) |=> frozen_o); // R10

    AST_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (frozen_o && ext_irq_i) |=> (!frozen_o && resume_o)); // R10

    AST_FROZEN_MUTE: assert property (@(posedge clk) disable iff (rst)
        frozen_o |=> !(exec_o || report_o || freeze_o)); // R9

    AST_NON_FP_RUNS: assert property (@(posedge clk) disable iff (rst)
        (!frozen_o && ins_valid_i && ins_class_i == CLS_W'(NON_FP_CODE)) |=> exec_o); // R8

    AST_CLEAN_RUNS: assert property (@(posedge clk) disable iff (rst)
        (!frozen_o && ins_valid_i && !err_pending_i) |=> exec_o); // R2

endmodule

bind fpgate_ctrl fpgate_ctrl_chk #(
    .CLS_W       (CLS_W),
    .NON_FP_CODE (NON_FP_CODE)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .ins_valid_i   (ins_valid_i),
    .ins_class_i   (ins_class_i),
    .err_pending_i (err_pending_i),
    .ext_irq_i     (ext_irq_i),
    .exec_o        (exec_o),
    .freeze_o      (freeze_o),
    .report_o      (report_o),
    .resume_o      (resume_o),
    .frozen_o      (frozen_o)
);

// File: tb/tb_fpgate_ctrl.sv
`timescale 1ns/1ps
module tb_fpgate_ctrl;
    logic       clk = 1'b0;
    logic       rst;
    logic       native_err_i, ignore_err_n_i, err_pending_i, dual_cfg_i;
    logic       ins_valid_i, ext_irq_i;
    logic [3:0] ins_class_i;
    logic       exec_o, freeze_o, report_o, resume_o, frozen_o;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    fpgate_ctrl dut (
        .clk            (clk),
        .rst            (rst),
        .native_err_i   (native_err_i),
        .ignore_err_n_i (ignore_err_n_i),
        .err_pending_i  (err_pending_i),
        .dual_cfg_i     (dual_cfg_i),
        .ins_valid_i    (ins_valid_i),
        .ins_class_i    (ins_class_i),
        .ext_irq_i      (ext_irq_i),
        .exec_o         (exec_o),
        .freeze_o       (freeze_o),
        .report_o       (report_o),
        .resume_o       (resume_o),
        .frozen_o       (frozen_o)
    );

    task automatic chk(input string req, input string what,
                       input logic act, input logic exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic chk_all(input string req, input logic e_ex, input logic e_fz,
                           input logic e_rp, input logic e_rs, input logic e_fl);
        chk(req, "exec",   exec_o,   e_ex);
        chk(req, "freeze", freeze_o, e_fz);
        chk(req, "report", report_o, e_rp);
        chk(req, "resume", resume_o, e_rs);
        chk(req, "frozen", frozen_o, e_fl);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; native_err_i = 0; ignore_err_n_i = 1; err_pending_i = 0;
        dual_cfg_i = 0; ins_valid_i = 0; ins_class_i = 0; ext_irq_i = 0;
        repeat (3) @(negedge clk);
        chk_all("R1", 0, 0, 0, 0, 0);
        rst = 1'b0;
        @(negedge clk);
        chk_all("R11", 0, 0, 0, 0, 0);

        for (int ne = 0; ne < 2; ne++)
        for (int ig = 0; ig < 2; ig++)
        for (int pd = 0; pd < 2; pd++)
        for (int du = 0; du < 2; du++)
        for (int cl = 0; cl < 16; cl++) begin
            logic  nonfp, exempt, ign_eff, e_ex, e_fz, e_rp;
            string req;
            nonfp   = (cl == 15);
            exempt  = (cl < 9);
            ign_eff = (ig == 0) && (du == 0) && (ne == 0);
            e_ex = 0; e_fz = 0; e_rp = 0;
            if (nonfp)        begin e_ex = 1; req = "R8"; end
            else if (pd == 0) begin e_ex = 1; req = "R2"; end
            else if (ne == 1) begin
                req = "R3";
                if (exempt) e_ex = 1; else e_rp = 1;
            end else if (ign_eff) begin e_ex = 1; req = "R4"; end
            else begin
                req = (ig == 0) ? "R7" : (exempt ? "R5" : "R6");
                if (exempt) e_ex = 1; else e_fz = 1;
            end
            native_err_i = ne[0]; ignore_err_n_i = ig[0]; err_pending_i = pd[0];
            dual_cfg_i = du[0]; ins_class_i = cl[3:0]; ins_valid_i = 1;
            @(negedge clk);
            ins_valid_i = 0;
            chk_all(req, e_ex, e_fz, e_rp, 0, e_fz);
            @(negedge clk);
            chk_all("R11", 0, 0, 0, 0, e_fz);
            if (e_fz) begin
                // valid non-FP instruction while frozen must be dropped
                ins_class_i = 4'd15; err_pending_i = 0; ins_valid_i = 1;
                @(negedge clk);
                ins_valid_i = 0;
                chk_all("R9", 0, 0, 0, 0, 1);
                repeat (3) @(negedge clk);
                chk_all("R10", 0, 0, 0, 0, 1);
                ext_irq_i = 1;
                @(negedge clk);
                ext_irq_i = 0;
                chk_all("R10", 0, 0, 0, 1, 0);
                @(negedge clk);
                chk_all("R10", 0, 0, 0, 0, 0);
            end
        end

        // reset while frozen
        native_err_i = 0; ignore_err_n_i = 1; err_pending_i = 1; dual_cfg_i = 0;
        ins_class_i = 4'd9; ins_valid_i = 1;
        @(negedge clk);
        ins_valid_i = 0;
        chk_all("R6", 0, 1, 0, 0, 1);
        rst = 1;
        @(negedge clk);
        rst = 0;
        chk_all("R1", 0, 0, 0, 0, 0);

        // back-to-back accepted instructions
        err_pending_i = 0; ins_class_i = 4'd3; ins_valid_i = 1;
        @(negedge clk);
        chk_all("R2", 1, 0, 0, 0, 0);
        @(negedge clk);
        ins_valid_i = 0;
        chk_all("R2", 1, 0, 0, 0, 0);
        @(negedge clk);
        chk_all("R11", 0, 0, 0, 0, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule